// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management end of an MII management link. A host hands it one request: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs the whole serial frame by itself. It generates the management clock and drives the data line through an output value and an output enable, so that the pad can tri-state it. During the turnaround and data bits of a read it releases the line and samples the PHY. When the frame is over it returns the read data and a turnaround-error flag along with a single-cycle completion pulse.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle. A request stays pending for as long as the host holds `req_valid`, and it is taken on the first edge where both signals are high. The response has no back-pressure. `rsp_valid` is a one-cycle pulse, and the consumer must take `rsp_rdata` and `rsp_ta_err` in that cycle. Both values stay unchanged until the next request is accepted.

The clock divider parameter `DIV_HALF` gives the number of system clock cycles in each half of a management clock period. The management clock must not exceed 2.5 MHz. The default of 40 meets this exactly at a 200 MHz system clock, and a slower system clock needs a proportionally smaller value. An optional per-request input drops the preamble, for PHYs that accept frames without one.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset and whenever the block is idle, `mdc` is 0, `mdio_oe` is 0 (line released), `req_ready` is 1 and `rsp_valid` is 0.
- R2: Each frame sends the following bits in order, all fields MSB first: preamble ones, the start pattern 0 then 1, then the opcode (read = 1,0; write = 0,1), then the 5-bit PHY address, then the 5-bit register address.
- R3: On a write, the master drives the two turnaround bits as 1 then 0, then the 16 data bits from bit 15 down to bit 0, then releases the line for one final idle bit time.
- R4: On a read, `mdio_oe` is 0 from the first turnaround bit through the final idle bit. The 16 bits sampled in the data field, MSB first, are returned on `rsp_rdata`. A write returns `rsp_rdata` = 0.
- R5: The preamble is `PRE_LEN` ones (default 32). If `pre_skip` is high when the request is accepted, the preamble is left out and the frame starts with the start pattern.
- R6: Each half period of `mdc` lasts exactly `DIV_HALF` clock cycles, and the first rising edge comes `DIV_HALF` cycles after acceptance. `mdio_o` and `mdio_oe` change only in the cycle where `mdc` falls, and never while it is high. `mdio_i` is sampled as `mdc` rises.
- R7: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the `rsp_valid` cycle. Requests offered while busy do not change the frame in progress.
- R8: `rsp_valid` is a single-cycle pulse. It appears exactly (P + 33) x 2 x `DIV_HALF` cycles after the accepting edge, where P is the preamble length in use.
- R9: `rsp_ta_err` is 1 after a read when the line was 1 at the second turnaround bit, meaning the PHY did not pull it to 0. Otherwise it is 0, and it is always 0 after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| pre_skip | input | 1 | Leave out the preamble for this request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data (0 after a write) |
| rsp_ta_err | output | 1 | PHY failed to drive 0 in the second turnaround bit |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Line value to drive |
| mdio_oe | output | 1 | Output enable for the line driver |
| mdio_i | input | 1 | Line value seen at the pad |

## Verification
The first `mdc` rise is due `DIV_HALF` edges after the accepting edge, and each later transition follows `DIV_HALF` edges after the previous one. `rsp_valid` is due (P + 33) x 2 x `DIV_HALF` edges after acceptance, and `rsp_rdata` and `rsp_ta_err` are valid in that same cycle. The bench counts clock edges from the accepting edge and samples every output at falling clock edges. It compares each transition and the completion pulse against those exact edge counts. It records the line at each `mdc` rise and checks it bit by bit against a frame it computes itself. It also confirms that the pulse is gone one cycle later.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam logic [1:0] SOF_PAT   = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] TA_DRIVE  = 2'b10;

  // body = start, opcode, phy, reg, turnaround, data
  localparam int BODY_BITS  = 32;
  localparam int TA_FIRST   = 14;
  localparam int TA_SECOND  = 15;
  localparam int DATA_FIRST = 16;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_req_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CMAX = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt == CMAX);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  mgmt_req_t  req_in,
  input  logic       pre_skip,
  input  logic       fall_tick,
  output logic       busy,
  output logic       done,
  output logic       wr_q,
  output logic       in_body,
  output logic [5:0] body_idx,
  output logic       mdio_o,
  output logic       mdio_oe
);
  localparam int LAST  = PRE_LEN + BODY_BITS;  // final idle bit position
  localparam int POS_W = $clog2(LAST + 1);
  localparam logic [POS_W-1:0] PRE_P  = POS_W'(PRE_LEN);
  localparam logic [POS_W-1:0] LAST_P = POS_W'(LAST);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] offs;
  mgmt_req_t        req_q;
  logic [31:0]      body_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pos   <= '0;
      req_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        req_q <= req_in;
        pos   <= pre_skip ? PRE_P : '0;
      end else if (busy && fall_tick) begin
        if (pos == LAST_P) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  assign wr_q      = req_q.wr;
  assign offs      = pos - PRE_P;
  assign body_idx  = offs[5:0];
  assign in_body   = busy && (pos >= PRE_P);
  assign body_word = {SOF_PAT, (req_q.wr ? OPC_WRITE : OPC_READ),
                      req_q.phy, req_q.regad, TA_DRIVE, req_q.wdata};

  always_comb begin
    mdio_o  = 1'b0;
    mdio_oe = 1'b0;
    if (busy) begin
      if (!in_body) begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b1;
      end else if ((body_idx < 6'(TA_FIRST)) ||
                   (req_q.wr && (body_idx < 6'(BODY_BITS)))) begin
        mdio_o  = body_word[5'd31 - body_idx[4:0]];
        mdio_oe = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_read_capture.sv
module mdio_read_capture
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        rise_tick,
  input  logic        in_body,
  input  logic        wr_q,
  input  logic [5:0]  body_idx,
  input  logic        mdio_i,
  output logic [15:0] rdata,
  output logic        ta_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      ta_err <= 1'b0;
    end else if (accept) begin
      rdata  <= '0;
      ta_err <= 1'b0;
    end else if (rise_tick && in_body && !wr_q) begin
      if (body_idx == 6'(TA_SECOND)) begin
        ta_err <= mdio_i;
      end else if ((body_idx >= 6'(DATA_FIRST)) && (body_idx < 6'(BODY_BITS))) begin
        rdata <= {rdata[14:0], mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 40,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        pre_skip,
  output logic        rsp_valid,
  output logic [15:0] rsp_rdata,
  output logic        rsp_ta_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic       busy, accept, rise_tick, fall_tick, wr_q, in_body;
  logic [5:0] body_idx;
  mgmt_req_t  req_in;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign req_in    = '{wr: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_in(req_in),
    .pre_skip(pre_skip), .fall_tick(fall_tick), .busy(busy), .done(rsp_valid),
    .wr_q(wr_q), .in_body(in_body), .body_idx(body_idx),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_read_capture u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rise_tick(rise_tick),
    .in_body(in_body), .wr_q(wr_q), .body_idx(body_idx), .mdio_i(mdio_i),
    .rdata(rsp_rdata), .ta_err(rsp_ta_err)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DIV_HALF = 40
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  logic        mdc_d;
  logic [15:0] since_tr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_d    <= 1'b0;
      since_tr <= '0;
    end else begin
      mdc_d <= mdc;
      if (req_ready)          since_tr <= '0;
      else if (mdc != mdc_d)  since_tr <= 16'd1;
      else                    since_tr <= since_tr + 16'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mdc && !mdio_oe));

  assert_half_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_d) |-> (since_tr == 16'(DIV_HALF)));

  assert_hold_while_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && mdc_d) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_accept_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind mdio_mgmt_master mdio_mgmt_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/100ps
module tb_mdio_mgmt_master;
  localparam int H   = 2;
  localparam int PRE = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, pre_skip = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ta_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;
  logic phy_en = 1'b0, phy_val = 1'b0;
  logic mdio_line;

  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic cap_v [0:79];
  logic cap_e [0:79];

  // pad model: master driver, else PHY driver, else pull-up
  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always #2.5 clk = ~clk;

  mdio_mgmt_master #(.DIV_HALF(H), .PRE_LEN(PRE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .pre_skip(pre_skip), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected {oe, line} for bit i of a frame (R2..R4)
  function automatic logic [1:0] exp_bit(input int i, input int pre, input logic wr,
      input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
      input logic [15:0] pd, input logic fault);
    int f;
    if (i < pre) return 2'b11;
    f = i - pre;
    if (f == 0) return 2'b10;
    if (f == 1) return 2'b11;
    if (f == 2) return {1'b1, ~wr};
    if (f == 3) return {1'b1, wr};
    if (f < 9)  return {1'b1, pa[8 - f]};
    if (f < 14) return {1'b1, ra[13 - f]};
    if (wr) begin
      if (f == 14) return 2'b11;
      if (f == 15) return 2'b10;
      if (f < 32)  return {1'b1, wd[31 - f]};
      return 2'b01;
    end
    if (f == 14) return 2'b01;
    if (f == 15) return {1'b0, fault};
    if (f < 32)  return {1'b0, pd[31 - f]};
    return 2'b01;
  endfunction

  task automatic run_txn(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
      input logic [15:0] wd, input logic skip, input logic [15:0] pd,
      input logic fault, input logic junk);
    int pre, nbits, k, nr, last_tr, hdr_bad, tail_bad;
    logic first, pm, po, poe, rdy_bad, tim_bad, hold_bad;
    logic [1:0] e;
    pre = skip ? 0 : PRE;
    nbits = pre + 33;
    nr = 0; k = 0; last_tr = 0; first = 1'b1;
    rdy_bad = 1'b0; tim_bad = 1'b0; hold_bad = 1'b0;
    phy_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = pa; req_reg = ra;
    req_wdata = wd; pre_skip = skip;
    chk(req_ready == 1'b1, "R7 ready before request", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      req_write = ~wr; req_phy = ~pa; req_reg = ~ra; req_wdata = ~wd; pre_skip = ~skip;
    end else begin
      req_valid = 1'b0;
    end
    pm = mdc; po = mdio_o; poe = mdio_oe;
    while (!rsp_valid && k < 5000) begin
      if (req_ready) rdy_bad = 1'b1;
      if (mdc != pm) begin
        if (first ? (k != H) : (k - last_tr != H)) tim_bad = 1'b1;
        first = 1'b0; last_tr = k;
        if (mdc) begin
          if (nr < 80) begin cap_v[nr] = mdio_line; cap_e[nr] = mdio_oe; end
          nr++;
        end else begin
          // PHY drives the next bit after a falling edge
          if (!wr && nr == pre + 15) begin
            phy_en = !fault; phy_val = 1'b0;
          end else if (!wr && nr >= pre + 16 && nr <= pre + 31) begin
            phy_en = 1'b1; phy_val = pd[15 - (nr - pre - 16)];
          end else begin
            phy_en = 1'b0;
          end
        end
      end else if (mdc && (mdio_o != po || mdio_oe != poe)) begin
        hold_bad = 1'b1;
      end
      pm = mdc; po = mdio_o; poe = mdio_oe;
      @(negedge clk);
      k++;
      if (junk && k == 20) req_valid = 1'b0;
    end
    phy_en = 1'b0;
    chk(k == nbits * 2 * H, "R8 completion latency", k, nbits * 2 * H);
    chk(nr == nbits, "R5 bit count incl preamble", nr, nbits);
    hdr_bad = 0; tail_bad = 0;
    for (int i = 0; i < nbits && i < 80; i++) begin
      e = exp_bit(i, pre, wr, pa, ra, wd, pd, fault);
      if ({cap_e[i], cap_v[i]} != e) begin
        if (i < pre + 14) hdr_bad++; else tail_bad++;
      end
    end
    chk(hdr_bad == 0, "R2 preamble/start/opcode/address bits", hdr_bad, 0);
    if (wr) chk(tail_bad == 0, "R3 write turnaround/data/idle bits", tail_bad, 0);
    else    chk(tail_bad == 0, "R4 read release and line bits", tail_bad, 0);
    chk(rsp_rdata == (wr ? 16'h0 : pd), "R4 returned data", rsp_rdata, wr ? 0 : pd);
    chk(rsp_ta_err == (!wr && fault), "R9 turnaround error flag", rsp_ta_err, !wr && fault);
    chk(!tim_bad, "R6 mdc half period", tim_bad, 0);
    chk(!hold_bad, "R6 outputs stable while mdc high", hold_bad, 0);
    chk(!rdy_bad, "R7 ready low while busy", rdy_bad, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 single-cycle pulse", rsp_valid, 0);
    chk(!mdc && !mdio_oe && req_ready, "R1 idle after frame", {mdc, mdio_oe, req_ready}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mdc == 1'b0, "R1 mdc low after reset", mdc, 0);
    chk(mdio_oe == 1'b0, "R1 line released after reset", mdio_oe, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    // sweep every register address, both directions, both preamble modes
    for (int r = 0; r < 32; r++) begin
      for (int w = 0; w < 2; w++) begin
        run_txn(w[0], 5'(r) ^ 5'h0A, 5'(r),
                {5'(r), ~5'(r), 6'(r * 3)}, 1'(r) ^ w[0],
                16'hA5C3 ^ (16'(r) * 16'h0101), 1'b0, (r % 4) == 1);
      end
    end
    // address/data extremes
    run_txn(1'b1, 5'h1F, 5'h1F, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0);
    run_txn(1'b0, 5'h00, 5'h00, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    // R9: PHY absent at second turnaround bit
    run_txn(1'b0, 5'h10, 5'h02, 16'h0000, 1'b0, 16'h1234, 1'b1, 1'b0);
    run_txn(1'b0, 5'h10, 5'h03, 16'h0000, 1'b1, 16'h8001, 1'b1, 1'b1);
    // R9: a following clean read clears the flag
    run_txn(1'b0, 5'h10, 5'h04, 16'h0000, 1'b0, 16'h5A5A, 1'b0, 1'b0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule